// File: doc/BRIEF.md
# Dual-Link Event Fragment Merger

This block collects event fragments arriving on two independent input links and turns each pair into one outgoing packet. Each link writes its words into a private buffer. When a fragment's last word arrives, the buffer records a descriptor holding the fragment's event ID and word count. Once every enabled link holds a complete fragment, the merger emits the packet in this order:

- one header word;
- the first link's words;
- the second link's words.

The header states the packet length, the source number, the event ID and a running packet number. If the event IDs of the two fragments differ, a sticky error flag is raised and the packet is still sent.

A two-bit configuration mask selects the contributing links. A masked link's input is discarded, and packets are then built from the remaining link alone. The mask and `src_id` are expected to change only while no packet is being built and no fragment is buffered. Buffer depth is a parameter. The full-size system uses 8192 words of 64 bits per link; the default here is small.

Top module: `frag_merge_packer`

## Requirements
- R1: Words accepted on an enabled link are buffered and leave the block in arrival order, with no loss or duplication, including while a previous packet is still draining.
- R2: Header field `[47:40]` carries `src_id`. Header field `[39:24]` carries the event ID of link 0 when link 0 is enabled, otherwise the event ID of link 1. A fragment's event ID is the value of `in_evid` on its first word.
- R3: Header bits `[15:0]` are reserved and always zero.
- R4: Every packet is sent as consecutive words in this order: header (with `out_sop` high), link 0 words, then link 1 words. `out_eop` is high only on the last word of the packet.
- R5: Header field `[63:48]` equals 1 plus the word counts of the enabled links' fragments.
- R6: Header field `[23:16]` is 0 in the first packet after reset, rises by one per packet, and wraps from 255 to 0.
- R7: With both links enabled, differing fragment event IDs set `evid_err`. The flag stays set until reset, and the packet is still emitted.
- R8: When `cfg_link_en[i]` is 0, words presented on link i are discarded and never appear at the output. Packets are then built from the other link only (mask bit 0 controls link 0, bit 1 controls link 1).
- R9: After reset, `out_valid` and `evid_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_link_en | input | 2 | Link enable mask; bit i enables link i |
| src_id | input | 8 | Source number placed in each header |
| in_valid0 | input | 1 | Link 0 word valid |
| in_last0 | input | 1 | Link 0 last word of fragment |
| in_data0 | input | 64 | Link 0 data word |
| in_evid0 | input | 16 | Link 0 event ID, sampled on a fragment's first word |
| in_valid1 | input | 1 | Link 1 word valid |
| in_last1 | input | 1 | Link 1 last word of fragment |
| in_data1 | input | 64 | Link 1 data word |
| in_evid1 | input | 16 | Link 1 event ID, sampled on a fragment's first word |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Output word is a packet header |
| out_eop | output | 1 | Output word ends the packet |
| out_data | output | 64 | Output word |
| evid_err | output | 1 | Sticky event-ID mismatch flag |

## Verification
The two functions that can fall in the same cycle are buffer writes from a new fragment and buffer reads by the merger draining the previous packet. The same overlap applies to descriptor push and pop. The bench provokes this by starting each event's input fragments while the previous packet is still leaving the block. Correctness is judged by comparing every output word, together with its `out_sop` and `out_eop` flags, against a queue of words predicted from the requirements. Any lost, repeated or reordered word shows up as a miscompare.

// File: rtl/fmrg_pkg.sv
package fmrg_pkg;
    localparam int WORD_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY0 = 2'd1,
        ST_BODY1 = 2'd2
    } mrg_state_e;
endpackage

// File: rtl/fmrg_link_buf.sv
module fmrg_link_buf #(
    parameter int DEPTH = 16,
    parameter int EV_W  = 16,
    parameter int LEN_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_last,
    input  logic [fmrg_pkg::WORD_W-1:0] wr_data,
    input  logic [EV_W-1:0]            wr_evid,
    input  logic                       rd_en,
    output logic [fmrg_pkg::WORD_W-1:0] rd_data,
    output logic                       rd_last,
    output logic                       desc_valid,
    output logic [EV_W-1:0]            desc_evid,
    output logic [LEN_W-1:0]           desc_len,
    input  logic                       desc_pop
);
    localparam int AW = $clog2(DEPTH);
    localparam int DW = fmrg_pkg::WORD_W;

    typedef struct packed {
        logic [AW:0]      wp;
        logic [AW:0]      rp;
        logic [AW:0]      dwp;
        logic [AW:0]      drp;
        logic             first;
        logic [EV_W-1:0]  cur_evid;
        logic [LEN_W-1:0] cur_len;
    } buf_t;

    buf_t s_q, s_d;
    logic [DW:0]           dmem [DEPTH];
    logic [EV_W+LEN_W-1:0] fmem [DEPTH];
    logic [EV_W-1:0]       evid_now;
    logic [LEN_W-1:0]      len_now;
    logic                  full;

    always_comb begin
        s_d      = s_q;
        evid_now = s_q.first ? wr_evid : s_q.cur_evid;
        len_now  = s_q.first ? LEN_W'(1) : s_q.cur_len + LEN_W'(1);
        if (wr_en) begin
            s_d.wp = s_q.wp + 1'b1;
            if (wr_last) begin
                s_d.first   = 1'b1;
                s_d.cur_len = '0;
                s_d.dwp     = s_q.dwp + 1'b1;
            end else begin
                s_d.first    = 1'b0;
                s_d.cur_len  = len_now;
                s_d.cur_evid = evid_now;
            end
        end
        if (rd_en)    s_d.rp  = s_q.rp + 1'b1;
        if (desc_pop) s_d.drp = s_q.drp + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.first <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) dmem[s_q.wp[AW-1:0]] <= {wr_last, wr_data};
        if (wr_en && wr_last) fmem[s_q.dwp[AW-1:0]] <= {evid_now, len_now};
    end

    assign full       = (s_q.wp[AW] != s_q.rp[AW]) && (s_q.wp[AW-1:0] == s_q.rp[AW-1:0]);
    assign rd_data    = dmem[s_q.rp[AW-1:0]][DW-1:0];
    assign rd_last    = dmem[s_q.rp[AW-1:0]][DW];
    assign desc_valid = (s_q.dwp != s_q.drp);
    assign desc_evid  = fmem[s_q.drp[AW-1:0]][EV_W+LEN_W-1:LEN_W];
    assign desc_len   = fmem[s_q.drp[AW-1:0]][LEN_W-1:0];

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R1
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (s_q.wp != s_q.rp));
    // R4
    desc_pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_pop |-> desc_valid);
endmodule

// File: rtl/frag_merge_packer.sv
module frag_merge_packer #(
    parameter int DEPTH = 16,
    parameter int EV_W  = 16,
    parameter int SEQ_W = 8,
    parameter int SZ_W  = 16,
    parameter int SRC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_link_en,
    input  logic [SRC_W-1:0]  src_id,
    input  logic              in_valid0,
    input  logic              in_last0,
    input  logic [63:0]       in_data0,
    input  logic [EV_W-1:0]   in_evid0,
    input  logic              in_valid1,
    input  logic              in_last1,
    input  logic [63:0]       in_data1,
    input  logic [EV_W-1:0]   in_evid1,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [63:0]       out_data,
    output logic              evid_err
);
    import fmrg_pkg::*;
    localparam int NLINK = 2;
    localparam int RSV_W = WORD_W - SZ_W - SRC_W - EV_W - SEQ_W;

    logic [NLINK-1:0]              lk_valid, lk_last, rd_en, rd_last, desc_valid, desc_pop;
    logic [NLINK-1:0][WORD_W-1:0]  lk_data, rd_data;
    logic [NLINK-1:0][EV_W-1:0]    lk_evid, desc_evid;
    logic [NLINK-1:0][SZ_W-1:0]    desc_len;

    assign lk_valid = {in_valid1, in_valid0};
    assign lk_last  = {in_last1, in_last0};
    assign lk_data  = {in_data1, in_data0};
    assign lk_evid  = {in_evid1, in_evid0};

    for (genvar i = 0; i < NLINK; i++) begin : g_link
        fmrg_link_buf #(.DEPTH(DEPTH), .EV_W(EV_W), .LEN_W(SZ_W)) u_buf (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (lk_valid[i] & cfg_link_en[i]),
            .wr_last    (lk_last[i]),
            .wr_data    (lk_data[i]),
            .wr_evid    (lk_evid[i]),
            .rd_en      (rd_en[i]),
            .rd_data    (rd_data[i]),
            .rd_last    (rd_last[i]),
            .desc_valid (desc_valid[i]),
            .desc_evid  (desc_evid[i]),
            .desc_len   (desc_len[i]),
            .desc_pop   (desc_pop[i])
        );
    end

    typedef struct packed {
        mrg_state_e        st;
        logic [NLINK-1:0]  en;
        logic [SEQ_W-1:0]  seq;
        logic              err;
        logic              ov;
        logic              osop;
        logic              oeop;
        logic [WORD_W-1:0] od;
    } mrg_t;

    mrg_t m_q, m_d;
    logic             start;
    logic [SZ_W-1:0]  pkt_size;
    logic [EV_W-1:0]  pkt_evid;

    always_comb begin
        m_d      = m_q;
        rd_en    = '0;
        desc_pop = '0;
        start    = (|cfg_link_en) && (!cfg_link_en[0] || desc_valid[0])
                                  && (!cfg_link_en[1] || desc_valid[1]);
        pkt_size = SZ_W'(1) + (cfg_link_en[0] ? desc_len[0] : '0)
                            + (cfg_link_en[1] ? desc_len[1] : '0);
        pkt_evid = cfg_link_en[0] ? desc_evid[0] : desc_evid[1];
        m_d.ov   = 1'b0;
        m_d.osop = 1'b0;
        m_d.oeop = 1'b0;
        unique case (m_q.st)
            ST_IDLE: begin
                if (start) begin
                    desc_pop = cfg_link_en;
                    m_d.en   = cfg_link_en;
                    if ((&cfg_link_en) && (desc_evid[0] != desc_evid[1])) m_d.err = 1'b1;
                    m_d.od   = {pkt_size, src_id, pkt_evid, m_q.seq, {RSV_W{1'b0}}};
                    m_d.ov   = 1'b1;
                    m_d.osop = 1'b1;
                    m_d.seq  = m_q.seq + 1'b1;
                    m_d.st   = cfg_link_en[0] ? ST_BODY0 : ST_BODY1;
                end
            end
            ST_BODY0: begin
                rd_en[0] = 1'b1;
                m_d.od   = rd_data[0];
                m_d.ov   = 1'b1;
                if (rd_last[0]) begin
                    m_d.st   = m_q.en[1] ? ST_BODY1 : ST_IDLE;
                    m_d.oeop = !m_q.en[1];
                end
            end
            ST_BODY1: begin
                rd_en[1] = 1'b1;
                m_d.od   = rd_data[1];
                m_d.ov   = 1'b1;
                if (rd_last[1]) begin
                    m_d.st   = ST_IDLE;
                    m_d.oeop = 1'b1;
                end
            end
            default: m_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign out_valid = m_q.ov;
    assign out_sop   = m_q.osop;
    assign out_eop   = m_q.oeop;
    assign out_data  = m_q.od;
    assign evid_err  = m_q.err;

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evid_err |=> evid_err);
    // R4
    hdr_then_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |=> (out_valid && !out_sop));
    // R4
    eop_not_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop) |-> !out_sop);
    // R4
    body_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |=> out_valid);
endmodule

// File: tb/frag_merge_packer_bench.sv
module frag_merge_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_link_en = 2'b11;
    logic [7:0]  src_id = 8'h5A;
    logic        in_valid0 = 0, in_last0 = 0, in_valid1 = 0, in_last1 = 0;
    logic [63:0] in_data0 = '0, in_data1 = '0;
    logic [15:0] in_evid0 = '0, in_evid1 = '0;
    logic        out_valid, out_sop, out_eop, evid_err;
    logic [63:0] out_data;

    int vectors = 0;
    int errors  = 0;
    logic [65:0] expq [$];
    logic [7:0]  exp_seq = 8'd0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    frag_merge_packer u_frag_merge_packer (
        .clk(clk), .rst_n(rst_n), .cfg_link_en(cfg_link_en), .src_id(src_id),
        .in_valid0(in_valid0), .in_last0(in_last0), .in_data0(in_data0), .in_evid0(in_evid0),
        .in_valid1(in_valid1), .in_last1(in_last1), .in_data1(in_data1), .in_evid1(in_evid1),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_data(out_data), .evid_err(evid_err)
    );

    function automatic logic [63:0] wd(int ln, int k, logic [15:0] e);
        return {16'(ln + 1), e, 16'(k), 16'hC0DE};
    endfunction

    task automatic cmp(string rq, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // output monitor: every word against the predicted stream
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                cmp("R8", "unexpected word", out_data, 64'hX);
            end else begin
                logic [65:0] e;
                e = expq.pop_front();
                cmp("R4", "sop", 64'(out_sop), 64'(e[65]));
                cmp("R4", "eop", 64'(out_eop), 64'(e[64]));
                if (e[65]) begin
                    cmp("R5", "size", 64'(out_data[63:48]), 64'(e[63:48]));
                    cmp("R2", "src", 64'(out_data[47:40]), 64'(e[47:40]));
                    cmp("R2", "evid", 64'(out_data[39:24]), 64'(e[39:24]));
                    cmp("R6", "seq", 64'(out_data[23:16]), 64'(e[23:16]));
                    cmp("R3", "reserved", 64'(out_data[15:0]), 64'(e[15:0]));
                end else begin
                    cmp("R1", "data", out_data, e[63:0]);
                end
            end
        end
    end

    task automatic drive_link(int ln, int len, logic [15:0] e);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (ln == 0) begin
                in_valid0 = 1; in_last0 = (k == len - 1); in_data0 = wd(0, k, e); in_evid0 = e;
            end else begin
                in_valid1 = 1; in_last1 = (k == len - 1); in_data1 = wd(1, k, e); in_evid1 = e;
            end
        end
        @(negedge clk);
        if (ln == 0) in_valid0 = 0; else in_valid1 = 0;
    endtask

    task automatic send_event(int l0, int l1, logic [15:0] e0, logic [15:0] e1);
        logic [15:0] sz;
        logic [15:0] ev;
        bit m0, m1;
        m0 = cfg_link_en[0];
        m1 = cfg_link_en[1];
        sz = 16'(1 + (m0 ? l0 : 0) + (m1 ? l1 : 0));
        ev = m0 ? e0 : e1;
        expq.push_back({1'b1, 1'b0, sz, src_id, ev, exp_seq, 16'h0000});
        exp_seq++;
        if (m0) for (int k = 0; k < l0; k++)
            expq.push_back({1'b0, (!m1 && k == l0 - 1), wd(0, k, e0)});
        if (m1) for (int k = 0; k < l1; k++)
            expq.push_back({1'b0, (k == l1 - 1), wd(1, k, e1)});
        fork
            drive_link(0, l0, e0);
            drive_link(1, l1, e1);
        join
        repeat (l0 + l1 + 2) @(negedge clk);
    endtask

    task automatic drain;
        while (expq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        cmp("R1", "pending words", 64'(expq.size()), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        cmp("R9", "out_valid", 64'(out_valid), 64'd0);
        cmp("R9", "evid_err", 64'(evid_err), 64'd0);
        rst_n = 1;
        @(negedge clk);

        // both links, matched IDs, all length pairs; overlaps draining with next input
        cfg_link_en = 2'b11;
        for (int a = 1; a <= 4; a++)
            for (int b = 1; b <= 4; b++)
                send_event(a, b, 16'(a * 16 + b), 16'(a * 16 + b));
        drain();
        cmp("R7", "no false error", 64'(evid_err), 64'd0);

        // R7 mismatch: packet still sent, flag set and sticky
        send_event(2, 3, 16'h0005, 16'h0006);
        drain();
        cmp("R7", "error set", 64'(evid_err), 64'd1);
        send_event(1, 1, 16'h0007, 16'h0007);
        drain();
        cmp("R7", "error sticky", 64'(evid_err), 64'd1);

        // R8 single-link operation with masked link driven
        cfg_link_en = 2'b01;
        src_id = 8'hC3;
        for (int a = 1; a <= 4; a++) send_event(a, 3, 16'(100 + a), 16'hDEAD);
        drain();
        cfg_link_en = 2'b10;
        for (int b = 1; b <= 4; b++) send_event(2, b, 16'hBEEF, 16'(200 + b));
        drain();

        // R6 packet number wrap
        cfg_link_en = 2'b01;
        for (int n = 0; n < 260; n++) send_event(1, 1, 16'(n), 16'(n));
        drain();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule